// File: doc/BRIEF.md
# Ten-Bit ECC Symbol Codec

This block sits between a multi-symbol ECC engine and the spare area of a flash page. On the write side, the engine leaves its check symbols in a set of 32-bit raw registers. Each register carries one 10-bit symbol in its lower half-word and one in its upper half-word. A pack request turns these registers into a dense byte string. Every group of four symbols fills exactly five bytes, so eight symbols fit in ten bytes. Bits above the tenth in each half-word are discarded.

On the read side, the ten stored bytes are handed back with an unpack request. If every byte is 0xFF, the code belongs to an erased page. In that case no symbols are produced and completion is reported at once with the erased flag set. Otherwise the bytes are split back into eight 10-bit symbols. The symbols go out on a valid/ready stream from the highest index down to index zero, which is the order the ECC engine's load port expects. A completion pulse follows the last accepted symbol.

Top module: `ecc_sym_codec`

## Requirements
- R1: After reset, packValid, symValid, done, erased and busy are all low.
- R2: Only bits 9:0 and 25:16 of each raw register affect packOut. All other raw bits are ignored (mask 0x03FF03FF).
- R3: Pass p uses registers 2p (values a at bits 9:0 and b at bits 25:16) and 2p+1 (values c at bits 9:0 and d at bits 25:16), and writes bytes 5p to 5p+4, where byte n sits at packOut[8n+7:8n]. The bytes are: a[7:0]; {b[5:0],a[9:8]}; {c[3:0],b[9:6]}; {d[1:0],c[9:4]}; d[9:2].
- R4: packValid is high for exactly the one cycle after a cycle with packReq high, and packOut holds the new bytes in that cycle.
- R5: An accepted unpackReq whose ten codeIn bytes are all 0xFF produces no symbols. In the next cycle, done and erased are both high. A code with any bit cleared is not treated as erased.
- R6: For a code that is not erased, symbols are presented with symIdx 7, 6, ..., 0, one per accepted handshake, and symValid rises in the cycle after acceptance.
- R7: Unpacking is the exact inverse of R3. Symbol 4p+k equals value k (a, b, c, d) of pass p, so packing any values and then unpacking the result returns them.
- R8: While symValid is high and symReady is low, symValid, symData and symIdx hold.
- R9: The cycle after symbol 0 is accepted, done is high for one cycle with erased low and symValid low.
- R10: unpackReq is accepted only while busy is low. A request made while busy has no effect on the symbols being streamed or on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| packReq | input | 1 | Capture and pack rawIn |
| rawIn | input | 32*NUM_REG | Raw registers; register r at bits 32r+31:32r |
| packValid | output | 1 | packOut updated this cycle |
| packOut | output | 40*NUM_REG/2 | Packed bytes, byte n at bits 8n+7:8n |
| unpackReq | input | 1 | Start unpacking codeIn (taken when not busy) |
| codeIn | input | 40*NUM_REG/2 | Stored code bytes, same byte layout as packOut |
| busy | output | 1 | Unpack in progress |
| symValid | output | 1 | Symbol on symData is valid |
| symReady | input | 1 | Load port accepts the symbol |
| symData | output | 10 | Current 10-bit symbol |
| symIdx | output | log2(2*NUM_REG) | Index of current symbol |
| done | output | 1 | One-cycle completion pulse |
| erased | output | 1 | With done: code was all 0xFF |

## Verification
The bench uses the default NUM_REG of 4, which gives eight symbols in ten bytes, two packing passes and a 3-bit index. This is the complete layout, so every byte equation of both passes is exercised. Random raw values with noise in the masked-off bits check the packing. Round trips under random ready stalls check ordering and hold behaviour. Directed cases cover an all-0xFF code, a code one bit short of erased, and a request made while busy.

// File: rtl/ecc_codec_pkg.sv
package ecc_codec_pkg;
  localparam int SYM_W = 10;

  typedef struct packed {
    logic loadCode;
    logic capPack;
  } ctlStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_STREAM, ST_FIN} ctlState_t;
endpackage

// File: rtl/ecc_codec_dp.sv
module ecc_codec_dp
  import ecc_codec_pkg::*;
#(
  parameter int NUM_REG = 4,
  localparam int SYM_N  = 2 * NUM_REG,
  localparam int PASSES = NUM_REG / 2,
  localparam int BYTE_N = 5 * PASSES,
  localparam int IDX_W  = $clog2(SYM_N)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctlStrobe_t            strobe,
  input  logic [32*NUM_REG-1:0] rawIn,
  input  logic [8*BYTE_N-1:0]   codeIn,
  input  logic [IDX_W-1:0]      rdIdx,
  output logic [8*BYTE_N-1:0]   packOut,
  output logic [SYM_W-1:0]      symData,
  output logic                  allOnes
);
  logic [8*BYTE_N-1:0] packNext;
  logic [8*BYTE_N-1:0] packReg;
  logic [8*BYTE_N-1:0] codeReg;
  logic [SYM_W-1:0]    symArr [SYM_N];
  logic [32*NUM_REG-1:0] maskedRaw;
  logic rawUnused;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_mask
    assign maskedRaw[32*r +: 32] = rawIn[32*r +: 32] & 32'h03FF03FF;
  end
  assign rawUnused = ^(maskedRaw ^ rawIn);

  for (genvar p = 0; p < PASSES; p++) begin : g_pass
    logic [SYM_W-1:0] va, vb, vc, vd;
    logic [39:0] grp;
    assign va = maskedRaw[64*p      +: 10];
    assign vb = maskedRaw[64*p + 16 +: 10];
    assign vc = maskedRaw[64*p + 32 +: 10];
    assign vd = maskedRaw[64*p + 48 +: 10];
    assign packNext[40*p +: 40] = {vd[9:2],
                                   vd[1:0], vc[9:4],
                                   vc[3:0], vb[9:6],
                                   vb[5:0], va[9:8],
                                   va[7:0]};
    assign grp = codeReg[40*p +: 40];
    for (genvar k = 0; k < 4; k++) begin : g_sym
      assign symArr[4*p + k] = grp[10*k +: 10];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      packReg <= '0;
      codeReg <= '0;
    end else begin
      if (strobe.capPack)  packReg <= packNext;
      if (strobe.loadCode) codeReg <= codeIn;
    end
  end

  assign packOut = packReg;
  assign symData = symArr[rdIdx];
  assign allOnes = &codeIn;
endmodule

// File: rtl/ecc_codec_ctl.sv
module ecc_codec_ctl
  import ecc_codec_pkg::*;
#(
  parameter int NUM_REG = 4,
  localparam int SYM_N  = 2 * NUM_REG,
  localparam int IDX_W  = $clog2(SYM_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             packReq,
  input  logic             unpackReq,
  input  logic             allOnes,
  input  logic             symReady,
  output ctlStrobe_t       strobe,
  output logic [IDX_W-1:0] idx,
  output logic             packValid,
  output logic             symValid,
  output logic             done,
  output logic             erased,
  output logic             busy
);
  ctlState_t state;
  logic erasedReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      erasedReg <= 1'b0;
      packValid <= 1'b0;
    end else begin
      packValid <= packReq;
      case (state)
        ST_IDLE: if (unpackReq) begin
          erasedReg <= allOnes;
          idx       <= IDX_W'(SYM_N - 1);
          state     <= allOnes ? ST_FIN : ST_STREAM;
        end
        ST_STREAM: if (symReady) begin
          if (idx == '0) state <= ST_FIN;
          else           idx   <= idx - IDX_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capPack  = packReq;
    strobe.loadCode = (state == ST_IDLE) && unpackReq;
  end

  assign symValid = (state == ST_STREAM);
  assign done     = (state == ST_FIN);
  assign erased   = done && erasedReg;
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/ecc_sym_codec.sv
module ecc_sym_codec
  import ecc_codec_pkg::*;
#(
  parameter int NUM_REG = 4,
  localparam int SYM_N  = 2 * NUM_REG,
  localparam int BYTE_N = 5 * (NUM_REG / 2),
  localparam int IDX_W  = $clog2(SYM_N)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  packReq,
  input  logic [32*NUM_REG-1:0] rawIn,
  output logic                  packValid,
  output logic [8*BYTE_N-1:0]   packOut,
  input  logic                  unpackReq,
  input  logic [8*BYTE_N-1:0]   codeIn,
  output logic                  busy,
  output logic                  symValid,
  input  logic                  symReady,
  output logic [SYM_W-1:0]      symData,
  output logic [IDX_W-1:0]      symIdx,
  output logic                  done,
  output logic                  erased
);
  ctlStrobe_t strobe;
  logic allOnes;

  ecc_codec_ctl #(.NUM_REG(NUM_REG)) u_ctl (
    .clk(clk), .rst_n(rst_n), .packReq(packReq), .unpackReq(unpackReq),
    .allOnes(allOnes), .symReady(symReady), .strobe(strobe), .idx(symIdx),
    .packValid(packValid), .symValid(symValid), .done(done),
    .erased(erased), .busy(busy)
  );

  ecc_codec_dp #(.NUM_REG(NUM_REG)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rawIn(rawIn),
    .codeIn(codeIn), .rdIdx(symIdx), .packOut(packOut),
    .symData(symData), .allOnes(allOnes)
  );
endmodule

// File: rtl/ecc_codec_chk.sv
module ecc_codec_chk #(
  parameter int NUM_REG = 4,
  localparam int IDX_W  = $clog2(2 * NUM_REG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             packReq,
  input logic             packValid,
  input logic             symValid,
  input logic             symReady,
  input logic [9:0]       symData,
  input logic [IDX_W-1:0] symIdx,
  input logic             done,
  input logic             erased
);
  AST_PACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    packReq |=> packValid); // R4
  AST_PACK_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !packReq |=> !packValid); // R4
  AST_ERASED_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    erased |-> done && !symValid); // R5
  AST_IDX_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    symValid && symReady && symIdx != '0 |=> symValid && symIdx == $past(symIdx) - IDX_W'(1)); // R6
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    symValid && !symReady |=> symValid && $stable(symData) && $stable(symIdx)); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    symValid && symReady && symIdx == '0 |=> done && !erased && !symValid); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

bind ecc_sym_codec ecc_codec_chk #(.NUM_REG(NUM_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .packReq(packReq), .packValid(packValid),
  .symValid(symValid), .symReady(symReady), .symData(symData),
  .symIdx(symIdx), .done(done), .erased(erased)
);

// File: tb/sim_ecc_sym_codec.sv
module sim_ecc_sym_codec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic packReq = 1'b0;
  logic [127:0] rawIn = '0;
  logic packValid;
  logic [79:0] packOut;
  logic unpackReq = 1'b0;
  logic [79:0] codeIn = '0;
  logic busy, symValid, done, erased;
  logic symReady = 1'b0;
  logic [9:0] symData;
  logic [2:0] symIdx;
  int nTests = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  ecc_sym_codec #(.NUM_REG(4)) u0 (
    .clk(clk), .rst_n(rst_n), .packReq(packReq), .rawIn(rawIn),
    .packValid(packValid), .packOut(packOut), .unpackReq(unpackReq),
    .codeIn(codeIn), .busy(busy), .symValid(symValid), .symReady(symReady),
    .symData(symData), .symIdx(symIdx), .done(done), .erased(erased)
  );

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [79:0] packRef(input logic [127:0] raw);
    logic [79:0] res;
    for (int p = 0; p < 2; p++) begin
      logic [31:0] ra, rb;
      logic [9:0] a, b, c, d;
      ra = raw[64*p +: 32];
      rb = raw[64*p + 32 +: 32];
      a = ra[9:0]; b = ra[25:16]; c = rb[9:0]; d = rb[25:16];
      res[40*p      +: 8] = a[7:0];
      res[40*p + 8  +: 8] = {b[5:0], a[9:8]};
      res[40*p + 16 +: 8] = {c[3:0], b[9:6]};
      res[40*p + 24 +: 8] = {d[1:0], c[9:4]};
      res[40*p + 32 +: 8] = d[9:2];
    end
    return res;
  endfunction

  function automatic logic [9:0] symRef(input logic [127:0] raw, input int s);
    int p, k;
    p = s / 4;
    k = s % 4;
    return raw[32*(2*p + k/2) + 16*(k%2) +: 10];
  endfunction

  function automatic logic [127:0] randRaw();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic doPack(input logic [127:0] raw);
    @(negedge clk);
    rawIn = raw;
    packReq = 1'b1;
    @(negedge clk);
    packReq = 1'b0;
    rawIn = randRaw();
    chk(packValid === 1'b1, "R4 packValid", 80'(packValid), 80'd1);
    chk(packOut === packRef(raw), "R3 R2 packOut", packOut, packRef(raw));
    @(negedge clk);
    chk(packValid === 1'b0, "R4 pulse width", 80'(packValid), 80'd0);
  endtask

  task automatic doUnpack(input logic [79:0] code, input bit expErased,
                          input logic [127:0] raw, input bit inject);
    int cnt;
    int guard;
    bit stall;
    logic [9:0] heldData;
    logic [2:0] heldIdx;
    @(negedge clk);
    codeIn = code;
    unpackReq = 1'b1;
    @(negedge clk);
    unpackReq = 1'b0;
    if (expErased) begin
      chk(done && erased && !symValid, "R5 erased done", {77'd0, done, erased, symValid}, 80'b110);
      @(negedge clk);
      chk(!busy && !done && !symValid, "R5 no symbols", {77'd0, busy, done, symValid}, 80'd0);
      return;
    end
    cnt = 0; guard = 0; stall = 0;
    while (cnt < 8 && guard < 200) begin
      guard++;
      chk(symValid === 1'b1, "R6 symValid during stream", 80'(symValid), 80'd1);
      if (stall)
        chk(symData === heldData && symIdx === heldIdx, "R8 hold under stall",
            {67'd0, symIdx, symData}, {67'd0, heldIdx, heldData});
      symReady = ($urandom % 3) != 0;
      if (inject && cnt == 3) begin
        unpackReq = 1'b1;
        codeIn = '1;
      end
      #1;
      if (symValid && symReady) begin
        chk(symIdx === 3'(7 - cnt), "R6 index order", 80'(symIdx), 80'(7 - cnt));
        chk(symData === symRef(raw, 7 - cnt), "R7 symbol value", 80'(symData), 80'(symRef(raw, 7 - cnt)));
        cnt++;
        stall = 0;
      end else begin
        stall = 1;
        heldData = symData;
        heldIdx = symIdx;
      end
      @(negedge clk);
      unpackReq = 1'b0;
    end
    symReady = 1'b0;
    chk(done && !erased && !symValid, "R9 done after last", {77'd0, done, erased, symValid}, 80'b100);
    @(negedge clk);
    chk(!busy && !done && !symValid, "R10 idle after done", {77'd0, busy, done, symValid}, 80'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [127:0] raw;
    logic [79:0] code;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!packValid && !symValid && !done && !erased && !busy, "R1 reset state",
        {75'd0, packValid, symValid, done, erased, busy}, 80'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!packValid && !symValid && !done && !erased && !busy, "R1 after reset",
        {75'd0, packValid, symValid, done, erased, busy}, 80'd0);

    // R2 R3 R4 directed corners and random packing
    doPack('0);
    doPack('1);
    doPack({4{32'hFC00FC00}});
    doPack({4{32'h03FF03FF}});
    for (int i = 0; i < 40; i++) doPack(randRaw());

    // R7 round trips through the pack path, with random stalls
    for (int i = 0; i < 20; i++) begin
      raw = randRaw();
      doPack(raw);
      code = packOut;
      doUnpack(code, 1'b0, raw, 1'b0);
    end

    // R5 erased code
    doUnpack('1, 1'b1, '0, 1'b0);
    // R5 a single cleared bit is not erased: all values 0x3FF except the lowest bit of symbol 0
    raw = {4{32'h03FF03FF}};
    raw[0] = 1'b0;
    code = packRef(raw);
    chk(code === {{79{1'b1}}, 1'b0}, "R5 near-erased code", code, {{79{1'b1}}, 1'b0});
    doUnpack(code, 1'b0, raw, 1'b0);

    // R10 a request while busy is ignored
    raw = randRaw();
    doUnpack(packRef(raw), 1'b0, raw, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule